// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside an Ethernet receive datapath and decides, once per frame, whether the frame should be kept. It collects the first six bytes of the frame (the destination address) as the datapath hands them over, classifies the address as broadcast, multicast or unicast, and compares it in parallel against a table of exact-match entries loaded through a small word-addressed register port.

The decision combines the table result with per-class accept switches. A complement switch inverts the table result, so the table can act as a block list instead of an allow list. Typical settings are: table compare plus broadcast for normal reception; the same plus all-multicast for multicast reception; and every accept and compare switch set for promiscuous reception.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset every register reads 0, `decision_valid_o` is low, and with all-zero settings every frame is rejected.
- R2: Register offsets: filter mode at 0x00 (bit 0 accept all unicast, bit 1 accept all multicast, bit 2 accept broadcast, bit 3 complement the table result, bit 4 enable table compare); entry enable at 0x04, where bit n enables entry n; entry n high word at 0x08+8n; entry n low word at 0x0C+8n. Mode bits 31:5, enable bits above the entry count, and low-word bits 15:0 read 0.
- R3: The high word holds address byte 0 in bits 31:24 down to byte 3 in bits 7:0. The low word holds byte 4 in bits 31:24 and byte 5 in bits 23:16. Byte 0 is the first byte received.
- R4: An entry hits only when its enable bit is set and all 48 address bits are equal. A disabled entry, or a one-bit difference, gives no hit.
- R5: An address is broadcast when all six bytes are 0xFF. It is multicast when bit 0 of byte 0 is 1 and it is not broadcast. Otherwise it is unicast.
- R6: Accept = (compare enabled AND table result) OR (broadcast AND bit 2) OR (multicast AND bit 1) OR (unicast AND bit 0).
- R7: With compare enabled, mode bit 3 inverts the table result, so an address that hits no enabled entry is accepted. With compare disabled, bit 3 has no effect.
- R8: `decision_valid_o` pulses high for exactly one cycle, in the cycle after the sixth address byte is taken. Idle cycles between bytes are allowed. Bytes after the sixth are ignored until the next frame start.
- R9: `frame_start_i` marks byte 0 and discards any partly collected address, so a new address is collected from that byte.
- R10: Writes to offsets that map to no register leave all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register byte offset for writes |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 8 | Register byte offset for reads |
| rd_data_o | output | 32 | Read data for `rd_addr_i` (combinational) |
| frame_start_i | input | 1 | High with the first byte of a frame |
| byte_valid_i | input | 1 | `byte_i` carries a received byte |
| byte_i | input | 8 | Received byte |
| decision_valid_o | output | 1 | One-cycle strobe marking a decision |
| accept_o | output | 1 | Decision: 1 keeps the frame; held until the next decision |

## Verification
The bench builds the block with its default of 16 table entries and an 8-bit register offset. This puts the last entry's words at 0x80 and 0x84, and the first unmapped offset at 0x88, within reach of directed writes. Random modes and enable masks are paired with addresses drawn from the table, from single-bit corruptions of table entries, from broadcast, and from random multicast and unicast values. This exercises every term of the accept expression and the complement. Random idle cycles between address bytes, trailing bytes after the sixth, and aborted partial frames test the collection counter.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam int MAC_BYTES    = 6;
  localparam int MODE_OFF     = 'h00;
  localparam int ENA_OFF      = 'h04;
  localparam int TBL_BASE     = 'h08;
  localparam int ENTRY_STRIDE = 8;

  // Field order follows the mode register bit positions (bit 0 = acc_uc).
  typedef struct packed {
    logic cmp_en;
    logic cmp_inv;
    logic acc_bc;
    logic acc_mc;
    logic acc_uc;
  } filt_mode_t;
endpackage

// File: rtl/rx_filt_regs.sv
module rx_filt_regs
  import rx_filt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int REG_AW      = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [REG_AW-1:0]             wr_addr_i,
  input  logic [31:0]                   wr_data_i,
  input  logic [REG_AW-1:0]             rd_addr_i,
  output logic [31:0]                   rd_data_o,
  output filt_mode_t                    mode_o,
  output logic [NUM_ENTRIES-1:0]        ena_o,
  output logic [NUM_ENTRIES-1:0][47:0]  tbl_o
);
  localparam int MODE_W = $bits(filt_mode_t);

  filt_mode_t                   mode_q;
  logic [NUM_ENTRIES-1:0]       ena_q;
  logic [NUM_ENTRIES-1:0][47:0] tbl_q;
  logic [NUM_ENTRIES-1:0]       hi_sel, lo_sel;
  logic                         mode_sel, ena_sel, wr_mapped;

  assign mode_sel = (wr_addr_i == REG_AW'(MODE_OFF));
  assign ena_sel  = (wr_addr_i == REG_AW'(ENA_OFF));

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_dec
    assign hi_sel[i] = (wr_addr_i == REG_AW'(TBL_BASE + ENTRY_STRIDE*i));
    assign lo_sel[i] = (wr_addr_i == REG_AW'(TBL_BASE + ENTRY_STRIDE*i + 4));
  end

  assign wr_mapped = mode_sel | ena_sel | (|hi_sel) | (|lo_sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ena_q  <= '0;
      tbl_q  <= '0;
    end else if (wr_en_i) begin
      if (mode_sel) mode_q <= filt_mode_t'(wr_data_i[MODE_W-1:0]);
      if (ena_sel)  ena_q  <= wr_data_i[NUM_ENTRIES-1:0];
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (hi_sel[i]) tbl_q[i][47:16] <= wr_data_i;
        if (lo_sel[i]) tbl_q[i][15:0]  <= wr_data_i[31:16];
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == REG_AW'(MODE_OFF)) rd_data_o = 32'(mode_q);
    if (rd_addr_i == REG_AW'(ENA_OFF))  rd_data_o = 32'(ena_q);
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (rd_addr_i == REG_AW'(TBL_BASE + ENTRY_STRIDE*i))
        rd_data_o = tbl_q[i][47:16];
      if (rd_addr_i == REG_AW'(TBL_BASE + ENTRY_STRIDE*i + 4))
        rd_data_o = {tbl_q[i][15:0], 16'h0000};
    end
  end

  assign mode_o = mode_q;
  assign ena_o  = ena_q;
  assign tbl_o  = tbl_q;

  // R10
  a_r10_unmapped_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_mapped |=> $stable(mode_q) && $stable(ena_q) && $stable(tbl_q));
endmodule

// File: rtl/rx_filt_capture.sv
module rx_filt_capture
  import rx_filt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        frame_start_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  output logic [47:0] da_o,
  output logic        last_o
);
  localparam int CNT_W = $clog2(MAC_BYTES + 1);

  logic [CNT_W-1:0]               cnt_q, cnt_eff;
  logic [MAC_BYTES-2:0][7:0]      hold_q;
  logic                           take;

  assign cnt_eff = frame_start_i ? '0 : cnt_q;
  assign take    = byte_valid_i && (cnt_eff < CNT_W'(MAC_BYTES));
  assign last_o  = take && (cnt_eff == CNT_W'(MAC_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(MAC_BYTES);
      hold_q <= '0;
    end else begin
      cnt_q <= take ? cnt_eff + 1'b1 : cnt_eff;
      for (int i = 0; i < MAC_BYTES - 1; i++)
        if (take && cnt_eff == CNT_W'(i)) hold_q[i] <= byte_i;
    end
  end

  // Byte 0 is the earliest byte and lands in the top octet.
  always_comb begin
    da_o[7:0] = byte_i;
    for (int i = 0; i < MAC_BYTES - 1; i++)
      da_o[47-8*i -: 8] = hold_q[i];
  end

  // R8, R9
  a_r8_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAC_BYTES));
  a_r9_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> cnt_q <= CNT_W'(1));
endmodule

// File: rtl/rx_filt_match.sv
module rx_filt_match
  import rx_filt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic [47:0]                   da_i,
  input  filt_mode_t                    mode_i,
  input  logic [NUM_ENTRIES-1:0]        ena_i,
  input  logic [NUM_ENTRIES-1:0][47:0]  tbl_i,
  output logic                          hit_o,
  output logic                          accept_o
);
  logic [NUM_ENTRIES-1:0] eq;
  logic is_bc, is_mc, is_uc, tbl_res;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
    assign eq[i] = ena_i[i] && (tbl_i[i] == da_i);
  end

  assign hit_o   = |eq;
  assign is_bc   = &da_i;
  assign is_mc   = da_i[40] && !is_bc;
  assign is_uc   = !da_i[40];
  assign tbl_res = mode_i.cmp_en && (hit_o ^ mode_i.cmp_inv);

  assign accept_o = tbl_res
                 || (is_bc && mode_i.acc_bc)
                 || (is_mc && mode_i.acc_mc)
                 || (is_uc && mode_i.acc_uc);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int REG_AW      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  input  logic              frame_start_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              decision_valid_o,
  output logic              accept_o
);
  filt_mode_t                   mode;
  logic [NUM_ENTRIES-1:0]       ena;
  logic [NUM_ENTRIES-1:0][47:0] tbl;
  logic [47:0]                  da;
  logic                         last, hit, acc;
  logic                         valid_q, accept_q;

  rx_filt_regs #(.NUM_ENTRIES(NUM_ENTRIES), .REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .mode_o(mode), .ena_o(ena), .tbl_o(tbl)
  );

  rx_filt_capture u_cap (
    .clk_i, .rst_ni, .frame_start_i, .byte_valid_i, .byte_i,
    .da_o(da), .last_o(last)
  );

  rx_filt_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .da_i(da), .mode_i(mode), .ena_i(ena), .tbl_i(tbl),
    .hit_o(hit), .accept_o(acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      valid_q <= last;
      if (last) accept_q <= acc;
    end
  end

  assign decision_valid_o = valid_q;
  assign accept_o         = accept_q;

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |=> !decision_valid_o);
  a_r8_follows_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(decision_valid_o) |-> $past(byte_valid_i));
  a_r9_no_decision_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !decision_valid_o);
  a_r6_zero_mode_rejects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && mode == '0 |=> !accept_o);
  a_r4_hit_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> ena != '0);
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        frame_start = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        dvalid, accept;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [4:0]  m_mode;
  logic [15:0] m_ena;
  logic [47:0] m_tbl [N];

  always #4 clk = ~clk;

  rx_addr_filter #(.NUM_ENTRIES(N), .REG_AW(8)) u_rx_addr_filter (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .frame_start_i(frame_start),
    .byte_valid_i(byte_valid), .byte_i(byte_in),
    .decision_valid_o(dvalid), .accept_o(accept)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_acc(input logic [47:0] da);
    bit bc, mc, uc, hit;
    bc = (da == 48'hFFFF_FFFF_FFFF);
    mc = da[40] && !bc;
    uc = !da[40];
    hit = 0;
    for (int i = 0; i < N; i++) if (m_ena[i] && m_tbl[i] == da) hit = 1;
    return (m_mode[4] && (hit ^ m_mode[3])) || (bc && m_mode[2]) ||
           (mc && m_mode[1]) || (uc && m_mode[0]);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_mode(input logic [4:0] m); wr(8'h00, 32'(m)); m_mode = m; endtask
  task automatic set_ena(input logic [15:0] e); wr(8'h04, 32'(e)); m_ena = e; endtask
  task automatic set_entry(input int i, input logic [47:0] da);
    wr(8'(8 + 8*i), da[47:16]);
    wr(8'(12 + 8*i), {da[15:0], 16'hBEEF});
    m_tbl[i] = da;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); rd_addr = a; #1;
    chk(req, 48'(rd_data), 48'(exp));
  endtask

  task automatic send_frame(input string req, input logic [47:0] da, input bit gaps,
                            input int extra);
    bit e;
    e = exp_acc(da);
    for (int i = 0; i < 6; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk); frame_start = 0; byte_valid = 0;
      end
      @(negedge clk);
      if (i > 0 && dvalid !== 1'b0) chk({req, " early strobe"}, 48'(dvalid), 48'd0);
      frame_start = (i == 0); byte_valid = 1; byte_in = da[47-8*i -: 8];
    end
    @(negedge clk);
    chk({req, " strobe"}, 48'(dvalid), 48'd1);
    chk({req, " accept"}, 48'(accept), 48'(e));
    frame_start = 0;
    byte_valid = (extra > 0);
    for (int k = 0; k < extra; k++) begin
      byte_in = 8'($urandom);
      @(negedge clk);
      chk("R8 trailing byte ignored", 48'(dvalid), 48'd0);
    end
    byte_valid = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, b, da;
    void'($urandom(32'd20240611));
    m_mode = '0; m_ena = '0;
    for (int i = 0; i < N; i++) m_tbl[i] = '0;

    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1: reset state
    chk("R1 valid after reset", 48'(dvalid), 48'd0);
    rd_chk("R1 mode reset", 8'h00, 32'h0);
    rd_chk("R1 enable reset", 8'h04, 32'h0);
    rd_chk("R1 entry0 hi reset", 8'h08, 32'h0);
    rd_chk("R1 entry15 lo reset", 8'h84, 32'h0);
    send_frame("R1 zero mode rejects", 48'h0000_0000_0000, 0, 0);
    send_frame("R1 zero mode rejects bc", 48'hFFFF_FFFF_FFFF, 0, 0);

    // R2, R3: register layout and byte packing
    wr(8'h00, 32'hFFFF_FFFF); m_mode = 5'h1F;
    rd_chk("R2 mode width", 8'h00, 32'h0000_001F);
    wr(8'h04, 32'hFFFF_FFFF); m_ena = 16'hFFFF;
    rd_chk("R2 enable width", 8'h04, 32'h0000_FFFF);
    set_entry(0, 48'h0011_2233_4455);
    set_entry(15, 48'hA0A1_A2A3_A4A5);
    rd_chk("R3 entry0 hi", 8'h08, 32'h0011_2233);
    rd_chk("R3 entry0 lo", 8'h0C, 32'h4455_0000);
    rd_chk("R2 entry15 hi", 8'h80, 32'hA0A1_A2A3);
    rd_chk("R2 entry15 lo", 8'h84, 32'hA4A5_0000);

    // R10: unmapped writes
    wr(8'h88, 32'h1234_5678);
    wr(8'h09, 32'h1234_5678);
    wr(8'hFC, 32'h1234_5678);
    rd_chk("R10 mode kept", 8'h00, 32'h0000_001F);
    rd_chk("R10 enable kept", 8'h04, 32'h0000_FFFF);
    rd_chk("R10 entry0 hi kept", 8'h08, 32'h0011_2233);
    rd_chk("R10 entry15 lo kept", 8'h84, 32'hA4A5_0000);

    // R3, R4: exact match only
    set_mode(5'b10000);
    set_ena(16'h0001);
    send_frame("R3 byte order match", 48'h0011_2233_4455, 0, 0);
    send_frame("R3 reversed bytes reject", 48'h5544_3322_1100, 0, 0);
    send_frame("R4 one bit off", 48'h0011_2233_4454, 0, 0);
    send_frame("R4 top bit off", 48'h8011_2233_4455, 0, 0);
    set_ena(16'h0000);
    send_frame("R4 disabled entry", 48'h0011_2233_4455, 0, 0);
    set_ena(16'h8000);
    send_frame("R4 last entry", 48'hA0A1_A2A3_A4A5, 0, 0);

    // R5, R6: classes
    set_mode(5'b00100);
    send_frame("R5 broadcast", 48'hFFFF_FFFF_FFFF, 0, 0);
    send_frame("R5 near broadcast is mc", 48'hFFFF_FFFF_FFFE, 0, 0);
    set_mode(5'b00010);
    send_frame("R5 multicast", 48'h0100_5E00_0001, 0, 0);
    send_frame("R5 broadcast not mc", 48'hFFFF_FFFF_FFFF, 0, 0);
    set_mode(5'b00001);
    send_frame("R5 unicast", 48'h0200_0000_0001, 0, 0);
    send_frame("R6 mc not uc", 48'h0300_0000_0001, 0, 0);
    set_mode(5'b10110);
    send_frame("R6 normal+mc table", 48'hA0A1_A2A3_A4A5, 0, 0);
    send_frame("R6 normal+mc unicast miss", 48'h0200_0000_0009, 0, 0);
    set_mode(5'b10111);
    send_frame("R6 promiscuous", 48'h0200_0000_0009, 0, 0);

    // R7: complement
    set_mode(5'b11000);
    send_frame("R7 inverted miss accepts", 48'h0200_0000_0009, 0, 0);
    send_frame("R7 inverted hit rejects", 48'hA0A1_A2A3_A4A5, 0, 0);
    set_mode(5'b01000);
    send_frame("R7 no compare no effect", 48'h0200_0000_0009, 0, 0);

    // R8: gaps and trailing bytes
    set_mode(5'b10000);
    send_frame("R8 gaps", 48'hA0A1_A2A3_A4A5, 1, 0);
    send_frame("R8 trailing", 48'hA0A1_A2A3_A4A5, 0, 5);

    // R9: aborted partial frame
    @(negedge clk); frame_start = 1; byte_valid = 1; byte_in = 8'h11;
    @(negedge clk); frame_start = 0; byte_in = 8'h22;
    @(negedge clk); byte_in = 8'h33;
    @(negedge clk); byte_valid = 0;
    chk("R9 partial gives no strobe", 48'(dvalid), 48'd0);
    send_frame("R9 restart", 48'hA0A1_A2A3_A4A5, 0, 0);

    // Random mix
    for (int i = 0; i < N; i++) set_entry(i, {$urandom, 16'($urandom)});
    for (int f = 0; f < 400; f++) begin
      if (f % 20 == 0) begin
        set_mode(5'($urandom));
        set_ena(16'($urandom));
      end
      a = m_tbl[$urandom % N];
      b = {$urandom, 16'($urandom)};
      case ($urandom % 5)
        0: da = a;
        1: da = a ^ (48'd1 << ($urandom % 48));
        2: da = 48'hFFFF_FFFF_FFFF;
        3: da = b | 48'h0100_0000_0000;
        default: da = b & ~48'h0100_0000_0000;
      endcase
      send_frame("R6 random", da, ($urandom % 2) == 1, $urandom % 3);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule